// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is the bus-facing side of a byte-addressed nonvolatile memory model attached to an I2C bus. It samples SCL and SDA on a fast system clock and recognises START and STOP conditions. It answers only when the address byte carries its device identity, and it pulls SDA low through an open-drain enable. A master uses it in three ways. It can write one byte or a burst of up to one page at a two-byte word address. It can read sequentially from a freshly set address. It can also read from wherever the internal pointer was left by the previous access.

Written bytes collect in a page buffer and go to the array only after the write ends with STOP. A timed programming interval then starts, and the block ignores the bus completely while it runs. The array depth is 2^ADDR_W bytes. A 16 KiB part uses ADDR_W = 14, and the default of 11 keeps elaboration small. The page size is 2^PAGE_W bytes (64 by default). The programming time is PROG_CLKS system clocks (3000 by default, and never less than one page).

Top module: `i2c_eeprom_target`

## Requirements
- R1: The address byte is accepted only when bits 7..4 equal 1010 and bits 3..1 equal strap[2:1:0]. A matching byte is acknowledged. Any other byte gets no acknowledge, and the block then ignores the bus until the next START or STOP.
- R2: Bit 0 of the address byte selects the direction: 1 starts a read and 0 starts a write.
- R3: An acknowledge means SDA is held low through the ninth SCL clock of a byte. In a write, every received byte is acknowledged: both address bytes and each data byte.
- R4: The first two bytes after a write address byte form the word address, high byte first. Only its low ADDR_W bits load the pointer, and the upper bits have no effect.
- R5: Data bytes reach the array only after a STOP ends the write. All bytes of that transaction are programmed in one cycle.
- R6: During a write, only the low PAGE_W pointer bits advance, so bytes past a page end wrap to the start of the same page. When more than one page of bytes is sent, later bytes replace earlier ones.
- R7: For PROG_CLKS clocks after the STOP that starts programming, SDA is never driven and no request gets an acknowledge, its own address included. After that, the block answers again.
- R8: In a read, the block drives 8 bits MSB first and then releases SDA in the ninth clock. A master ACK (SDA low) starts the next byte. A NACK leaves SDA released until START or STOP. SDA is released after reset.
- R9: The pointer advances after every byte read and wraps from the last location to 0. A read that sends no word address starts at the location after the last one read.
- R10: A write ended by START or STOP before any data byte is complete starts no programming cycle. A write ended by START after data bytes discards those bytes.
- R11: A START at any bit position restarts reception at a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock line as seen by the block |
| sdaIn | input | 1 | Bus data line as seen by the block |
| strap | input | 3 | Device identity straps compared with address bits 3..1 |
| sdaOe | output | 1 | Pulls SDA low when high (open-drain enable) |

## Verification
Address bytes are sent with a matching identity, a wrong strap field and a wrong fixed prefix. This separates the acknowledge decision from the ignore-until-STOP behaviour. Writes are tried as a single byte, as a 66-byte burst that starts two bytes before a page end, and as writes cut short by START. Reading the page back shows the in-page wrap and the overwrite order, and shows that a discarded or aborted write changed nothing. Reads are tried with ACK and NACK, across the last array location, with no word address after a previous read, and after a START in the middle of a byte. These show pointer wrap, pointer retention and bus release.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AHI, ST_AHI_ACK, ST_ALO, ST_ALO_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RDAT_ACK, ST_WAIT
  } bus_state_t;

  // Single-cycle strobes from control to datapath
  typedef struct packed {
    logic sdaBit;
    logic shiftIn;
    logic loadHi;
    logic loadPtr;
    logic storeData;
    logic ptrInc;
    logic txLoad;
    logic txShift;
    logic progStart;
    logic clearBuf;
  } strobe_t;

endpackage

// File: rtl/i2c_eeprom_ctrl.sv
module i2c_eeprom_ctrl
  import i2c_eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic [7:0] rxByte,
  input  logic       busy,
  output strobe_t    st,
  output logic       ackDrive,
  output logic       txDrive,
  output logic       sclHigh,
  output logic       stopEv
);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS, sclRise, sclFall, startEv;

  bus_state_t state, stateNxt;
  logic [2:0] bitCnt, bitCntNxt;
  logic [1:0] ph, phNxt;
  logic       ackNxt, txNxt, isRead, isReadNxt, mAck, mAckNxt, dataSeen, dataSeenNxt;

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclHigh = sclS;

  always_comb begin
    stateNxt    = state;
    bitCntNxt   = bitCnt;
    phNxt       = ph;
    ackNxt      = ackDrive;
    txNxt       = txDrive;
    isReadNxt   = isRead;
    mAckNxt     = mAck;
    dataSeenNxt = dataSeen;
    st          = '0;
    st.sdaBit   = sdaS;
    if (busy) begin
      stateNxt = ST_IDLE;
      ackNxt   = 1'b0;
      txNxt    = 1'b0;
    end else if (startEv) begin
      stateNxt  = ST_DEV;
      bitCntNxt = '0;
      phNxt     = '0;
      ackNxt    = 1'b0;
      txNxt     = 1'b0;
      if (dataSeen) begin
        st.clearBuf = 1'b1;
        dataSeenNxt = 1'b0;
      end
    end else if (stopEv) begin
      stateNxt = ST_IDLE;
      ackNxt   = 1'b0;
      txNxt    = 1'b0;
      if (dataSeen) begin
        st.progStart = 1'b1;
        dataSeenNxt  = 1'b0;
      end
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (sclRise) begin
            st.shiftIn = 1'b1;
            bitCntNxt  = bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              phNxt = '0;
              case (state)
                ST_DEV:  stateNxt = ST_DEV_ACK;
                ST_AHI:  stateNxt = ST_AHI_ACK;
                ST_ALO:  stateNxt = ST_ALO_ACK;
                default: stateNxt = ST_WDAT_ACK;
              endcase
            end
          end
        end
        ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
          if (ph == 2'd0 && sclFall) begin
            phNxt  = 2'd1;
            ackNxt = 1'b1;
            case (state)
              ST_DEV_ACK: begin
                if (rxByte[7:1] != {DEV_PREFIX, strap}) begin
                  ackNxt   = 1'b0;
                  stateNxt = ST_WAIT;
                end else begin
                  isReadNxt = rxByte[0];
                end
              end
              ST_AHI_ACK: st.loadHi  = 1'b1;
              ST_ALO_ACK: st.loadPtr = 1'b1;
              default: begin
                st.storeData = 1'b1;
                dataSeenNxt  = 1'b1;
              end
            endcase
          end else if (ph == 2'd1 && sclRise) begin
            phNxt = 2'd2;
          end else if (ph == 2'd2 && sclFall) begin
            ackNxt    = 1'b0;
            bitCntNxt = '0;
            case (state)
              ST_DEV_ACK: begin
                if (isRead) begin
                  st.txLoad = 1'b1;
                  txNxt     = 1'b1;
                  stateNxt  = ST_RDAT;
                end else begin
                  stateNxt = ST_AHI;
                end
              end
              ST_AHI_ACK: stateNxt = ST_ALO;
              default:    stateNxt = ST_WDAT;
            endcase
          end
        end
        ST_RDAT: begin
          if (sclRise) begin
            bitCntNxt = bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              phNxt    = '0;
              stateNxt = ST_RDAT_ACK;
            end
          end else if (sclFall) begin
            st.txShift = 1'b1;
          end
        end
        ST_RDAT_ACK: begin
          if (ph == 2'd0 && sclFall) begin
            txNxt     = 1'b0;
            st.ptrInc = 1'b1;
            phNxt     = 2'd1;
          end else if (ph == 2'd1 && sclRise) begin
            mAckNxt = ~sdaS;
            phNxt   = 2'd2;
          end else if (ph == 2'd2 && sclFall) begin
            bitCntNxt = '0;
            if (mAck) begin
              st.txLoad = 1'b1;
              txNxt     = 1'b1;
              stateNxt  = ST_RDAT;
            end else begin
              stateNxt = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync  <= 2'b11;
      sdaSync  <= 2'b11;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ph       <= '0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
      isRead   <= 1'b0;
      mAck     <= 1'b0;
      dataSeen <= 1'b0;
    end else begin
      sclSync  <= {sclSync[0], scl};
      sdaSync  <= {sdaSync[0], sdaIn};
      sclPrev  <= sclS;
      sdaPrev  <= sdaS;
      state    <= stateNxt;
      bitCnt   <= bitCntNxt;
      ph       <= phNxt;
      ackDrive <= ackNxt;
      txDrive  <= txNxt;
      isRead   <= isReadNxt;
      mAck     <= mAckNxt;
      dataSeen <= dataSeenNxt;
    end
  end

endmodule

// File: rtl/i2c_eeprom_dpath.sv
module i2c_eeprom_dpath
  import i2c_eeprom_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int PROG_CLKS = 3000
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    st,
  output logic [7:0] rxByte,
  output logic       txMsb,
  output logic       busy
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int TMR_W  = $clog2(PROG_CLKS + 1);

  logic [7:0]        hiByte, txReg, rdData;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE_N-1:0] pValid;
  logic [7:0]        pBuf [PAGE_N];
  logic [7:0]        mem  [DEPTH];
  logic [TMR_W-1:0]  tmr;
  logic [PAGE_W:0]   cIdx;
  logic              commitEn;

  assign txMsb    = txReg[7];
  assign commitEn = busy & ~cIdx[PAGE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      hiByte <= '0;
      txReg  <= '0;
      ptr    <= '0;
      pValid <= '0;
      busy   <= 1'b0;
      tmr    <= '0;
      cIdx   <= '0;
    end else begin
      if (st.shiftIn) rxByte <= {rxByte[6:0], st.sdaBit};
      if (st.loadHi)  hiByte <= rxByte;
      if (st.loadPtr) begin
        ptr <= ADDR_W'({hiByte, rxByte});
      end else if (st.storeData) begin
        pValid[ptr[PAGE_W-1:0]] <= 1'b1;
        ptr[PAGE_W-1:0]         <= ptr[PAGE_W-1:0] + 1'b1;
      end else if (st.ptrInc) begin
        ptr <= ptr + 1'b1;
      end
      if (st.txLoad)       txReg <= rdData;
      else if (st.txShift) txReg <= {txReg[6:0], 1'b0};
      if (st.clearBuf) pValid <= '0;
      if (st.progStart) begin
        busy <= 1'b1;
        tmr  <= TMR_W'(PROG_CLKS - 1);
        cIdx <= '0;
      end else if (busy) begin
        if (commitEn) cIdx <= cIdx + 1'b1;
        if (tmr == '0) begin
          busy   <= 1'b0;
          pValid <= '0;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.storeData) pBuf[ptr[PAGE_W-1:0]] <= rxByte;
  end

  // One buffered byte per clock goes to the array inside the timed window
  always_ff @(posedge clk) begin
    if (commitEn && pValid[cIdx[PAGE_W-1:0]])
      mem[{ptr[ADDR_W-1:PAGE_W], cIdx[PAGE_W-1:0]}] <= pBuf[cIdx[PAGE_W-1:0]];
    rdData <= mem[ptr];
  end

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_eeprom_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int PROG_CLKS = 3000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  output logic       sdaOe
);

  strobe_t    st;
  logic [7:0] rxByte;
  logic       txMsb, busy, ackDrive, txDrive, sclHigh, stopEv;

  i2c_eeprom_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .strap(strap),
    .rxByte(rxByte), .busy(busy), .st(st), .ackDrive(ackDrive),
    .txDrive(txDrive), .sclHigh(sclHigh), .stopEv(stopEv)
  );

  i2c_eeprom_dpath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CLKS(PROG_CLKS)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .rxByte(rxByte), .txMsb(txMsb), .busy(busy)
  );

  assign sdaOe = ackDrive | (txDrive & ~txMsb);

endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk #(
  parameter int PROG_CLKS = 3000
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic sdaOe,
  input logic sclHigh,
  input logic stopEv
);

  int unsigned busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else           busyLen <= 0;
  end

  // R7
  silent_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  // R7
  prog_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(busy)) |-> (busyLen == PROG_CLKS));

  // R5
  prog_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEv));

  // R8
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclHigh);

endmodule

bind i2c_eeprom_target i2c_eeprom_chk #(.PROG_CLKS(PROG_CLKS)) chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sdaOe(sdaOe),
  .sclHigh(sclHigh), .stopEv(stopEv)
);

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;

  localparam int Q    = 10;
  localparam int PROG = 3000;
  localparam logic [7:0] DEVW = 8'hAA;
  localparam logic [7:0] DEVR = 8'hAB;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclDrv = 1'b1;
  logic       mLow = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       sdaOe;
  wire        sdaLine = ~(mLow | sdaOe);

  i2c_eeprom_target #(.PROG_CLKS(PROG)) uut (
    .clk(clk), .rstN(rstN), .scl(sclDrv), .sdaIn(sdaLine), .strap(strap), .sdaOe(sdaOe)
  );

  typedef struct { logic [7:0] v; string req; } item_t;
  item_t      expQ[$];
  logic [7:0] actQ[$];
  item_t      eItem;
  logic [7:0] aVal;
  int checks = 0, fails = 0;

  // Monitor: compares each observed bus result against the next expected item
  always @(negedge clk) begin
    if (actQ.size() > 0 && expQ.size() > 0) begin
      eItem = expQ.pop_front();
      aVal  = actQ.pop_front();
      checks++;
      if (aVal !== eItem.v) begin
        fails++;
        $display("FAIL %s actual=%02h expected=%02h", eItem.req, aVal, eItem.v);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect8(logic [7:0] v, string req);
    expQ.push_back('{v, req});
  endtask

  task automatic sendStart();
    mLow = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(Q);
    mLow = 1'b1; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic sendStop();
    mLow = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    mLow = 1'b0; tick(Q);
  endtask

  task automatic bitOut(logic b);
    mLow = ~b; tick(Q);
    sclDrv = 1'b1; tick(2 * Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic bitIn(output logic b);
    mLow = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(Q);
    b = sdaLine; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic wrByte(logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    bitIn(r);
    actQ.push_back({7'b0, ~r});
  endtask

  task automatic rdByte(logic ackIt);
    logic [7:0] v;
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitIn(r);
      v[i] = r;
    end
    actQ.push_back(v);
    bitOut(~ackIt);
  endtask

  task automatic setAddr(logic [7:0] hi, logic [7:0] lo, string req);
    sendStart();
    expect8(8'h01, req);        wrByte(DEVW);
    expect8(8'h01, "R3 addr hi"); wrByte(hi);
    expect8(8'h01, "R3 addr lo"); wrByte(lo);
  endtask

  function automatic logic [7:0] pageDat(int k);
    return 8'(k * 7 + 3);
  endfunction

  initial begin
    tick(10);
    rstN = 1'b1;
    tick(10);
    checks++;
    if (sdaOe !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset release actual=%0b expected=0", sdaOe);
    end

    // R1: strap mismatch, then bus ignored until STOP
    sendStart();
    expect8(8'h00, "R1 strap mismatch");   wrByte(8'hA0);
    expect8(8'h00, "R1 ignored after mismatch"); wrByte(8'h12);
    sendStop();
    // R1: wrong fixed prefix
    sendStart();
    expect8(8'h00, "R1 prefix mismatch");  wrByte({4'hB, 3'b101, 1'b0});
    sendStop();

    // Byte write 0x0123 = 5A
    setAddr(8'h01, 8'h23, "R1 match");
    expect8(8'h01, "R3 data ack"); wrByte(8'h5A);
    sendStop();
    // R7: silent during programming
    sendStart();
    expect8(8'h00, "R7 no ack while busy"); wrByte(DEVW);
    sendStop();
    tick(PROG + 200);

    // Random read via aborted write (R10) and read direction (R2)
    setAddr(8'h01, 8'h23, "R7 acks after cycle");
    sendStart();
    expect8(8'h01, "R10 no cycle after address-only write"); wrByte(DEVR);
    expect8(8'h5A, "R2 R5 read back");   rdByte(1'b0);
    sendStop();

    // R10: data then START discards
    setAddr(8'h01, 8'h23, "R10 setup");
    expect8(8'h01, "R3 data ack"); wrByte(8'hEE);
    sendStart();
    expect8(8'h01, "R10 discard starts no cycle"); wrByte(DEVW);
    expect8(8'h01, "R3 addr hi"); wrByte(8'h01);
    expect8(8'h01, "R3 addr lo"); wrByte(8'h23);
    sendStart();
    expect8(8'h01, "R2 read ack"); wrByte(DEVR);
    expect8(8'h5A, "R10 discarded data"); rdByte(1'b0);
    sendStop();

    // R4 R6: 66 bytes at 0xF9FE -> page 0x1C0 offset 62
    setAddr(8'hF9, 8'hFE, "R4 setup");
    for (int k = 0; k < 66; k++) begin
      expect8(8'h01, "R6 page byte ack");
      wrByte(pageDat(k));
    end
    sendStop();
    tick(PROG + 200);
    setAddr(8'h01, 8'hC0, "R6 readback setup");
    sendStart();
    expect8(8'h01, "R2 read ack"); wrByte(DEVR);
    for (int o = 0; o < 64; o++) begin
      expect8(pageDat(o + 2), "R4 R5 R6 page content");
      rdByte(o != 63);
    end
    sendStop();

    // R9: wrap from last location to zero
    setAddr(8'h07, 8'hFF, "R9 setup");
    expect8(8'h01, "R3 data ack"); wrByte(8'h77);
    sendStop();
    tick(PROG + 200);
    setAddr(8'h00, 8'h00, "R9 setup");
    expect8(8'h01, "R3 data ack"); wrByte(8'h11);
    expect8(8'h01, "R3 data ack"); wrByte(8'h22);
    sendStop();
    tick(PROG + 200);
    setAddr(8'h07, 8'hFF, "R9 setup");
    sendStart();
    expect8(8'h01, "R2 read ack"); wrByte(DEVR);
    expect8(8'h77, "R9 last location"); rdByte(1'b1);
    expect8(8'h11, "R9 wrap to zero"); rdByte(1'b0);
    sendStop();
    sendStart();
    expect8(8'h01, "R9 current read ack"); wrByte(DEVR);
    expect8(8'h22, "R9 pointer holds next"); rdByte(1'b0);
    sendStop();

    // R8: after NACK the block stays off the bus
    setAddr(8'h00, 8'h00, "R8 setup");
    sendStart();
    expect8(8'h01, "R2 read ack"); wrByte(DEVR);
    expect8(8'h11, "R8 first byte"); rdByte(1'b0);
    expect8(8'hFF, "R8 released after NACK"); rdByte(1'b0);
    sendStop();

    // R11: START in the middle of a byte
    sendStart();
    expect8(8'h01, "R11 setup"); wrByte(DEVW);
    bitOut(1'b1); bitOut(1'b0); bitOut(1'b1);
    setAddr(8'h07, 8'hFF, "R11 address after mid-byte START");
    sendStart();
    expect8(8'h01, "R11 read ack"); wrByte(DEVR);
    expect8(8'h77, "R11 read after restart"); rdByte(1'b0);
    sendStop();

    tick(20);
    if (expQ.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", expQ.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule